// File: doc/BRIEF.md
# Lane-Partitioned Vector Integer ALU

This block is a 128-bit integer vector ALU with one registered output stage. Each cycle it takes two source vectors and a mask vector, and it returns one 128-bit result one clock later. The sources are never modified. For the arithmetic operations, the element-size select splits the vector into independent lanes of 8, 16 or 32 bits. A single adder path is cut at the lane edges, so no carry crosses from one lane into the next.

Within each lane the operands are read as signed or unsigned. A lane that goes out of range can either wrap around or be clamped to its range. The lane carry (or no-borrow) bit can be returned in place of the sum. An average operation rounds upward without losing the top bit of the sum. The bitwise operations work on the full 128 bits. A sticky flag records that at least one lane has clamped, and it stays set until it is cleared.

Top module: `simd_int_alu`

## Requirements
- R1: While `rst_n` is low, `result` and `sat_flag` read zero.
- R2: `result` reflects the inputs present at the previous rising clock edge. It does not change between edges.
- R3: The size select `esize` picks the lane width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. For ADD (op 0) and SUB (op 1, a minus b) with `saturate` low, each lane wraps modulo its width, and no carry or borrow moves between lanes.
- R4: For ADD and SUB with `saturate` high, an out-of-range lane is clamped. With `is_signed` high it clamps to the signed maximum or minimum. With `is_signed` low it clamps to all ones or to zero.
- R5: ADDC (op 2) puts the unsigned carry-out of each lane sum in bit 0 of that lane. SUBC (op 3) puts 1 in bit 0 when a ≥ b unsigned, meaning no borrow. All other bits of each lane are zero.
- R6: AVG (op 4) gives floor((a+b+1)/2) per lane. The sum is one bit wider than the lane, with sign or zero extension taken from `is_signed`. The result never overflows.
- R7: The bitwise operations act on all 128 bits regardless of `esize`: AND (op 5), OR (op 6), XOR (op 7), a AND NOT b (op 8), and NOT a (op 9).
- R8: SEL (op 10) takes each result bit from `b` where the matching `c` bit is 1, and from `a` where it is 0.
- R9: `sat_flag` is set on the edge after any lane clamps under R4. No other operation sets it, and ADD or SUB with `saturate` low never sets it.
- R10: `sat_flag` stays set until `sat_clr` is high at an edge in which no lane clamps. If a clamp and `sat_clr` occur in the same cycle, the flag stays set.
- R11: Opcodes 11 to 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 128 | First source vector |
| b | input | 128 | Second source vector |
| c | input | 128 | Bit-select mask for SEL |
| op | input | 4 | Operation code |
| esize | input | 2 | Lane size select |
| is_signed | input | 1 | Read lanes as signed |
| saturate | input | 1 | Clamp instead of wrap on ADD/SUB |
| sat_clr | input | 1 | Clear the sticky clamp flag |
| result | output | 128 | Registered result |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
Every operation, including the clamp flag update, is due exactly one rising edge after its inputs are applied. The bench drives inputs on the falling edge and compares `result` and `sat_flag` on the following falling edge, which comes after the single register stage has loaded. One directed check samples just before that rising edge to confirm that `result` still holds the previous value. Expected lanes are rebuilt with integer arithmetic from random and corner operands, such as lane maxima, all-ones and values next to lane boundaries.

// File: rtl/simd_int_alu.sv
module simd_int_alu #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] c,
  input  logic [3:0]       op,
  input  logic [1:0]       esize,
  input  logic             is_signed,
  input  logic             saturate,
  input  logic             sat_clr,
  output logic [WIDTH-1:0] result,
  output logic             sat_flag
);

  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_ADDC = 4'd2, OP_SUBC = 4'd3,
                         OP_AVG = 4'd4, OP_AND = 4'd5, OP_OR = 4'd6, OP_XOR = 4'd7,
                         OP_ANDC = 4'd8, OP_NOT = 4'd9, OP_SEL = 4'd10;
  localparam int NSZ = 3;

  logic [WIDTH-1:0] lane_res [NSZ];
  logic [WIDTH-1:0] lane_lsb [NSZ];
  logic [NSZ-1:0]   lane_sat;

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int W = 8 << s;
    localparam int N = WIDTH / W;
    logic [N-1:0] sat_v;

    for (genvar l = 0; l < N; l++) begin : g_ln
      logic [W-1:0] la, lb, clamp, out;
      logic [W+1:0] ea, eb, pick;
      logic ovf, arith, cadd, nbor;

      assign la = a[l*W +: W];
      assign lb = b[l*W +: W];
      assign ea = is_signed ? {{2{la[W-1]}}, la} : {2'b00, la};
      assign eb = is_signed ? {{2{lb[W-1]}}, lb} : {2'b00, lb};
      assign pick = (op == OP_SUB) ? ea - eb : ea + eb;
      assign arith = (op == OP_ADD) || (op == OP_SUB);
      assign ovf = is_signed ? !(pick[W+1:W-1] == 3'b000 || pick[W+1:W-1] == 3'b111)
                             : (pick[W+1:W] != 2'b00);
      assign clamp = is_signed ? (pick[W+1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                               : (pick[W+1] ? {W{1'b0}} : {W{1'b1}});
      assign cadd = ((({1'b0, la} + {1'b0, lb}) >> W) != 0);
      assign nbor = (la >= lb);

      always_comb begin
        case (op)
          OP_ADD, OP_SUB: out = (saturate && ovf) ? clamp : pick[W-1:0];
          OP_ADDC:        out = W'(cadd);
          OP_SUBC:        out = W'(nbor);
          OP_AVG:         out = W'((ea + eb + (W+2)'(1)) >> 1);
          default:        out = '0;
        endcase
      end

      assign lane_res[s][l*W +: W] = out;
      assign lane_lsb[s][l*W +: W] = W'(1);
      assign sat_v[l] = arith && saturate && ovf;
    end

    assign lane_sat[s] = |sat_v;
  end

  logic [WIDTH-1:0] arith_res, lsb_sel, next_res;
  logic             sat_now;
  logic [1:0]       sz;

  assign sz        = (esize == 2'd3) ? 2'd2 : esize;
  assign arith_res = lane_res[sz];
  assign lsb_sel   = lane_lsb[sz];
  assign sat_now   = lane_sat[sz];

  always_comb begin
    case (op)
      OP_AND:  next_res = a & b;
      OP_OR:   next_res = a | b;
      OP_XOR:  next_res = a ^ b;
      OP_ANDC: next_res = a & ~b;
      OP_NOT:  next_res = ~a;
      OP_SEL:  next_res = (b & c) | (a & ~c);
      default: next_res = arith_res;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      sat_flag <= 1'b0;
    end else begin
      result   <= next_res;
      sat_flag <= (sat_flag && !sat_clr) || sat_now;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (result == '0 && !sat_flag));

  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);

  p_no_sat_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!saturate && !sat_flag) |=> !sat_flag);

  p_carry_lsb_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADDC || op == OP_SUBC) |=> ((result & ~$past(lsb_sel)) == '0));

  p_not_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOT) |=> (result == ~$past(a)));

  p_sel_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SEL && c == '0) |=> (result == $past(a)));

endmodule

// File: tb/test_simd_int_alu.sv
`timescale 1ns/1ps
module test_simd_int_alu;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [127:0] a = '0, b = '0, c = '0;
  logic [3:0] op = '0;
  logic [1:0] esize = '0;
  logic is_signed = 1'b0, saturate = 1'b0, sat_clr = 1'b0;
  logic [127:0] result;
  logic sat_flag;
  int compared = 0, mismatched = 0;
  logic exp_flag = 1'b0;

  always #2.5 clk = ~clk;

  simd_int_alu i_simd_int_alu (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .c(c), .op(op),
    .esize(esize), .is_signed(is_signed), .saturate(saturate), .sat_clr(sat_clr),
    .result(result), .sat_flag(sat_flag));

  function automatic string tag_of(logic [3:0] o, logic st);
    if (o <= 4'd1) return st ? "R4" : "R3";
    if (o <= 4'd3) return "R5";
    if (o == 4'd4) return "R6";
    if (o <= 4'd9) return "R7";
    if (o == 4'd10) return "R8";
    return "R11";
  endfunction

  function automatic logic [127:0] model(input logic [127:0] x, y, m, input logic [3:0] o,
      input logic [1:0] es, input logic sg, st, output logic sat);
    logic [127:0] r;
    int w;
    longint mask, xa, xb, ua, ub, v, lo, hi;
    sat = 1'b0;
    case (o)
      4'd5: return x & y;
      4'd6: return x | y;
      4'd7: return x ^ y;
      4'd8: return x & ~y;
      4'd9: return ~x;
      4'd10: return (y & m) | (x & ~m);
      4'd11, 4'd12, 4'd13, 4'd14, 4'd15: return '0;
      default: ;
    endcase
    w = 8 << ((es == 2'd3) ? 2 : es);
    mask = (longint'(1) << w) - 1;
    r = '0;
    for (int l = 0; l < 128 / w; l++) begin
      ua = longint'((x >> (l * w)) & 128'(mask));
      ub = longint'((y >> (l * w)) & 128'(mask));
      xa = (sg && ua[w-1]) ? ua - (longint'(1) << w) : ua;
      xb = (sg && ub[w-1]) ? ub - (longint'(1) << w) : ub;
      lo = sg ? -(longint'(1) << (w - 1)) : 0;
      hi = sg ? (longint'(1) << (w - 1)) - 1 : mask;
      case (o)
        4'd0, 4'd1: begin
          v = (o == 4'd0) ? xa + xb : xa - xb;
          if (st && (v > hi || v < lo)) begin
            sat = 1'b1;
            v = (v > hi) ? hi : lo;
          end
        end
        4'd2: v = ((ua + ub) >> w) & 1;
        4'd3: v = (ua >= ub) ? 1 : 0;
        default: v = (xa + xb + 1) >>> 1;
      endcase
      r |= (128'(v & mask) << (l * w));
    end
    return r;
  endfunction

  task automatic run(input logic [127:0] x, y, m, input logic [3:0] o, input logic [1:0] es,
      input logic sg, st, clr);
    logic [127:0] exp;
    logic s;
    a = x; b = y; c = m; op = o; esize = es; is_signed = sg; saturate = st; sat_clr = clr;
    exp = model(x, y, m, o, es, sg, st, s);
    exp_flag = (exp_flag && !clr) || s;
    @(negedge clk);
    compared++;
    if (result !== exp) begin
      mismatched++;
      $display("FAIL %s op=%0d es=%0d sg=%0b st=%0b got %h exp %h", tag_of(o, st), o, es, sg, st, result, exp);
    end
    compared++;
    if (sat_flag !== exp_flag) begin
      mismatched++;
      $display("FAIL R9/R10 sat_flag got %0b exp %0b", sat_flag, exp_flag);
    end
  endtask

  initial begin
    #750000;
    compared++; mismatched++;
    $display("FAIL watchdog expired got hang exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [127:0] prev;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    compared++;
    if (result !== '0 || sat_flag !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset got %h/%0b exp 0/0", result, sat_flag);
    end
    rst_n = 1'b1;
    @(negedge clk);
    run({16{8'hFF}}, {16{8'h01}}, '0, 4'd0, 2'd1, 1'b0, 1'b0, 1'b0);   // R3 lane isolation
    run({16{8'h00}}, {16{8'h01}}, '0, 4'd1, 2'd0, 1'b0, 1'b0, 1'b0);   // R3 borrow wraps
    run({16{8'h7F}}, {16{8'h01}}, '0, 4'd0, 2'd0, 1'b1, 1'b1, 1'b0);   // R4 signed max, R9
    run({16{8'h00}}, '0, '0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0);             // R10 holds
    run('0, '0, '0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b1);                     // R10 clear
    run({8{16'h8000}}, {8{16'h0001}}, '0, 4'd1, 2'd1, 1'b1, 1'b1, 1'b1); // R4 signed min, R10 set wins
    run({4{32'hFFFF_FFFF}}, {4{32'h1}}, '0, 4'd0, 2'd2, 1'b0, 1'b1, 1'b1); // R4 unsigned max
    run({4{32'h5}}, {4{32'h9}}, '0, 4'd1, 2'd3, 1'b0, 1'b1, 1'b1);     // R4 unsigned floor
    run({16{8'hFF}}, {16{8'h01}}, '0, 4'd2, 2'd0, 1'b0, 1'b0, 1'b1);   // R5 carry
    run({8{16'h1234}}, {8{16'h1234}}, '0, 4'd3, 2'd1, 1'b0, 1'b0, 1'b0); // R5 equal -> 1
    run({16{8'hFF}}, {16{8'h00}}, '0, 4'd4, 2'd0, 1'b1, 1'b0, 1'b0);   // R6 signed -1+0
    run({16{8'hFF}}, {16{8'h00}}, '0, 4'd4, 2'd0, 1'b0, 1'b0, 1'b0);   // R6 unsigned 255+0
    run({16{8'h80}}, {16{8'h80}}, '0, 4'd4, 2'd0, 1'b1, 1'b0, 1'b0);   // R6 min+min
    run({4{32'hDEAD_BEEF}}, {4{32'h0F0F_F0F0}}, {4{32'hFF00_FF00}}, 4'd10, 2'd0, 1'b0, 1'b0, 1'b0); // R8
    run({4{32'hDEAD_BEEF}}, {4{32'h0F0F_F0F0}}, '0, 4'd13, 2'd0, 1'b0, 1'b1, 1'b0); // R11
    // R2: result must not move before the edge
    prev = result;
    a = ~a; op = 4'd9;
    #1;
    compared++;
    if (result !== prev) begin
      mismatched++;
      $display("FAIL R2 early change got %h exp %h", result, prev);
    end
    @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      run({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
          {$urandom, $urandom, $urandom, $urandom}, 4'($urandom % 16), 2'($urandom % 4),
          1'($urandom), 1'($urandom), 1'(($urandom % 8) == 0));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule